// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over many clock cycles and produces one quotient bit per cycle. A single wide shift register carries the partial remainder in its upper half and gathers quotient bits in its lower half. A divisor register and one subtractor complete the datapath. A one-cycle start request loads both operands. The register is shifted once, and the loop then runs once for each quotient bit. A final step corrects the remainder half and, in signed mode, the signs of both results. A one-cycle done pulse then presents the quotient and remainder.

The caller chooses unsigned or signed operation with each request. In signed mode the division runs on operand magnitudes, and sign correction follows the loop. A zero divisor does not stop the sequence. It raises a status flag and forces fixed result values.

Top module: `restoring_divider`

## Requirements
- R1: In unsigned mode (`signed_i` = 0), `quotient_o` equals floor(dividend / divisor) and `remainder_o` equals dividend mod divisor, for any non-zero divisor.
- R2: In signed mode (`signed_i` = 1), operands are two's complement. The quotient truncates toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend (-7 / 2 gives -3 remainder -1).
- R3: `done_o` rises on the 34th rising clock edge (WIDTH + 2) after the edge that accepts a start, for every operand pair.
- R4: `busy_o` is high from the edge after an accepted start until `done_o` rises. A start seen while `busy_o` is high is ignored and does not change the running operation's result.
- R5: `done_o` is high for exactly one cycle. `quotient_o`, `remainder_o` and `div_zero_o` hold their values until the next accepted operation completes.
- R6: A zero divisor sets `div_zero_o` together with `done_o`. The quotient is all ones and the remainder equals the dividend as given. The next operation with a non-zero divisor clears the flag.
- R7: Unsigned divisors with the top bit set are divided correctly. The partial remainder keeps the bit that is shifted out of the upper half.
- R8: In signed mode, the most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R9: After reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `quotient_o` and `remainder_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request; accepted when not busy |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled with an accepted start |
| divisor_i | input | 32 | Divisor, sampled with an accepted start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient of the last operation |
| remainder_o | output | 32 | Remainder of the last operation |
| div_zero_o | output | 1 | Last operation had a zero divisor |

## Verification
Unsigned pairs cover three cases: small values, a dividend smaller than the divisor, and equal operands. Together they separate errors in the quotient bits from errors in the final remainder shift. Divisors with the top bit set show whether the bit that leaves the upper half is lost. All four sign combinations, plus the most negative value over -1, separate quotient negation from remainder negation. Zero divisors, a start issued mid-run, and the cycles after done check the flag, the ignore rule, the fixed latency and the holding of the outputs.

// File: rtl/div_pkg.sv
// Package: shared types for the sequential divider.
// Assumes nothing beyond standard SystemVerilog.
package div_pkg;

    // Sequencer phases of one division
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_LOOP  = 2'd2,
        PH_FIX   = 2'd3
    } div_phase_e;

endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Turns the raw operands into magnitudes and sign flags. In unsigned mode
// the operands pass through unchanged and both sign flags read 0.
// Assumes two's complement encoding; the most negative value maps to its
// own bit pattern, which is its correct unsigned magnitude.
module div_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] dvd_mag_o,
    output logic [WIDTH-1:0] dvs_mag_o,
    output logic             dvd_neg_o,
    output logic             dvs_neg_o
);

    // Sign extraction and magnitude conversion
    always_comb begin
        dvd_neg_o = signed_i & dividend_i[WIDTH-1];
        dvs_neg_o = signed_i & divisor_i[WIDTH-1];
        dvd_mag_o = dvd_neg_o ? (~dividend_i + 1'b1) : dividend_i;
        dvs_mag_o = dvs_neg_o ? (~divisor_i + 1'b1) : divisor_i;
    end

endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequencer: accepts a start when idle, runs one pre-shift cycle, WIDTH
// loop cycles and one fix-up cycle, then returns to idle.
// Assumes start_i is ignored whenever the sequencer is not idle.
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic preshift_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    div_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase decode into datapath strobes
    always_comb begin
        busy_o     = (phase_q != PH_IDLE);
        load_o     = (phase_q == PH_IDLE) && start_i;
        preshift_o = (phase_q == PH_SHIFT);
        step_o     = (phase_q == PH_LOOP);
        fix_o      = (phase_q == PH_FIX);
    end

    // Phase register and loop counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) phase_q <= PH_SHIFT;
                    cnt_q <= '0;
                end
                PH_SHIFT: phase_q <= PH_LOOP;
                PH_LOOP: begin
                    if (cnt_q == LAST_STEP) begin
                        phase_q <= PH_FIX;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FIX: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_LOOP) |-> (cnt_q == '0)); // R3
    AST_LOOP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q != LAST_STEP) |=> (step_o && cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_START_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fix_o && start_i) |=> busy_o); // R4

endmodule

// File: rtl/div_iter_core.sv
// Module: div_iter_core
// Shift-register datapath. An extra carry bit above the upper half keeps
// the bit shifted out, so partial remainders up to twice the divisor fit.
// Loop step: trial-subtract the divisor from {carry, upper}; keep the
// difference and shift in 1, or keep the old value (restore) and shift in 0.
// Assumes load, preshift and step are mutually exclusive.
module div_iter_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             preshift_i,
    input  logic             step_i,
    input  logic             fix_i,
    input  logic [WIDTH-1:0] dvd_mag_i,
    input  logic [WIDTH-1:0] dvs_mag_i,
    output logic [WIDTH-1:0] rem_raw_o,
    output logic [WIDTH-1:0] quo_raw_o
);

    logic             carry_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH+1:0] trial;
    logic             trial_neg;

    // Trial subtraction on the widened partial remainder
    always_comb begin
        trial     = {1'b0, carry_q, hi_q} - {2'b00, dvs_q};
        trial_neg = trial[WIDTH+1];
    end

    // Shift register and divisor register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            hi_q    <= '0;
            lo_q    <= '0;
            dvs_q   <= '0;
        end else if (load_i) begin
            carry_q <= 1'b0;
            hi_q    <= '0;
            lo_q    <= dvd_mag_i;
            dvs_q   <= dvs_mag_i;
        end else if (preshift_i) begin
            {carry_q, hi_q, lo_q} <= {hi_q, lo_q, 1'b0};
        end else if (step_i) begin
            if (trial_neg) begin
                {carry_q, hi_q, lo_q} <= {hi_q, lo_q, 1'b0};
            end else begin
                {carry_q, hi_q, lo_q} <= {trial[WIDTH-1:0], lo_q, 1'b1};
            end
        end
    end

    // Undo the extra shift on the remainder half only
    always_comb begin
        rem_raw_o = {carry_q, hi_q[WIDTH-1:1]};
        quo_raw_o = lo_q;
    end

    AST_PRESHIFT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        preshift_i |=> !carry_q); // R7
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_i && dvs_q != '0) |-> (rem_raw_o < dvs_q)); // R1

endmodule

// File: rtl/div_result.sv
// Module: div_result
// Captures the operation's sign context at load. On the fix-up cycle it
// applies sign correction, or the zero-divisor override, into the output
// registers and raises the done pulse.
// Assumes load_i and fix_i never coincide.
module div_result #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             fix_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] dvs_mag_i,
    input  logic             dvd_neg_i,
    input  logic             dvs_neg_i,
    input  logic [WIDTH-1:0] rem_raw_i,
    input  logic [WIDTH-1:0] quo_raw_i,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o,
    output logic             done_o
);

    logic             neg_quo_q;
    logic             neg_rem_q;
    logic             zero_q;
    logic [WIDTH-1:0] dvd_raw_q;
    logic [WIDTH-1:0] quo_fix;
    logic [WIDTH-1:0] rem_fix;

    // Sign context captured with the operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
            dvd_raw_q <= '0;
        end else if (load_i) begin
            neg_quo_q <= dvd_neg_i ^ dvs_neg_i;
            neg_rem_q <= dvd_neg_i;
            zero_q    <= (dvs_mag_i == '0);
            dvd_raw_q <= dividend_i;
        end
    end

    // Sign correction and zero-divisor override
    always_comb begin
        if (zero_q) begin
            quo_fix = '1;
            rem_fix = dvd_raw_q;
        end else begin
            quo_fix = neg_quo_q ? (~quo_raw_i + 1'b1) : quo_raw_i;
            rem_fix = neg_rem_q ? (~rem_raw_i + 1'b1) : rem_raw_i;
        end
    end

    // Output registers and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient_o  <= '0;
            remainder_o <= '0;
            div_zero_o  <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= fix_i;
            if (fix_i) begin
                quotient_o  <= quo_fix;
                remainder_o <= rem_fix;
                div_zero_o  <= zero_q;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_ZERO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> (quotient_o == '1)); // R6

endmodule

// File: rtl/restoring_divider.sv
// Module: restoring_divider (top)
// Multi-cycle restoring divider, one quotient bit per cycle, with unsigned
// and signed modes. Result latency is WIDTH + 2 edges after an accepted start.
// Assumes operands are only sampled on the accepting edge.
module restoring_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o
);

    logic             load;
    logic             preshift;
    logic             step;
    logic             fix;
    logic [WIDTH-1:0] dvd_mag;
    logic [WIDTH-1:0] dvs_mag;
    logic             dvd_neg;
    logic             dvs_neg;
    logic [WIDTH-1:0] rem_raw;
    logic [WIDTH-1:0] quo_raw;

    div_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .dvd_mag_o  (dvd_mag),
        .dvs_mag_o  (dvs_mag),
        .dvd_neg_o  (dvd_neg),
        .dvs_neg_o  (dvs_neg)
    );

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .load_o     (load),
        .preshift_o (preshift),
        .step_o     (step),
        .fix_o      (fix),
        .busy_o     (busy_o)
    );

    div_iter_core #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .preshift_i (preshift),
        .step_i     (step),
        .fix_i      (fix),
        .dvd_mag_i  (dvd_mag),
        .dvs_mag_i  (dvs_mag),
        .rem_raw_o  (rem_raw),
        .quo_raw_o  (quo_raw)
    );

    div_result #(.WIDTH(WIDTH)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .fix_i       (fix),
        .dividend_i  (dividend_i),
        .dvs_mag_i   (dvs_mag),
        .dvd_neg_i   (dvd_neg),
        .dvs_neg_i   (dvs_neg),
        .rem_raw_i   (rem_raw),
        .quo_raw_i   (quo_raw),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .div_zero_o  (div_zero_o),
        .done_o      (done_o)
    );

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o))); // R5

endmodule

// File: tb/test_restoring_divider.sv
`timescale 1ns/1ps
module test_restoring_divider;

    localparam int W = 32;
    localparam int LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;
    logic         div_zero_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    restoring_divider #(.WIDTH(W)) i_restoring_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
        .done_o(done_o), .quotient_o(quotient_o), .remainder_o(remainder_o),
        .div_zero_o(div_zero_o)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected results from the requirements (R1, R2, R6)
    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                         output logic [W-1:0] q, output logic [W-1:0] r, output bit z);
        logic [W-1:0] ma, mb;
        bit na, nb;
        z = (b == '0);
        if (z) begin
            q = '1; r = a;
        end else begin
            na = sgn && a[W-1];
            nb = sgn && b[W-1];
            ma = na ? -a : a;
            mb = nb ? -b : b;
            q = ma / mb;
            r = ma % mb;
            if (na ^ nb) q = -q;
            if (na) r = -r;
        end
    endtask

    // Runs one division, optionally firing a stray start mid-run (R4)
    task automatic run_div(input string req, input logic [W-1:0] a,
                           input logic [W-1:0] b, input bit sgn, input bit stray);
        logic [W-1:0] eq, er;
        bit ez;
        int k;
        bit busy_ok;
        model(a, b, sgn, eq, er, ez);
        @(negedge clk);
        start_i = 1'b1; signed_i = sgn; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0;
        dividend_i = ~a; divisor_i = b ^ 32'h5;
        k = 0;
        busy_ok = 1'b1;
        while (!done_o && k < 200) begin
            if (!busy_o) busy_ok = 1'b0;
            if (stray && k == 5) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            k++;
        end
        check("R3", {req, " latency"}, W'(k), W'(LAT));
        check("R4", {req, " busy until done"}, W'(busy_ok), W'(1));
        check("R4", {req, " busy low at done"}, W'(busy_o), W'(0));
        check(req, "quotient", quotient_o, eq);
        check(req, "remainder", remainder_o, er);
        check("R6", {req, " zero flag"}, W'(div_zero_o), W'(ez));
        @(negedge clk);
        check("R5", {req, " done one cycle"}, W'(done_o), W'(0));
        check("R5", {req, " quotient held"}, quotient_o, eq);
        check("R5", {req, " remainder held"}, remainder_o, er);
    endtask

    task automatic test_reset();
        check("R9", "busy", W'(busy_o), W'(0));
        check("R9", "done", W'(done_o), W'(0));
        check("R9", "zero flag", W'(div_zero_o), W'(0));
        check("R9", "quotient", quotient_o, '0);
        check("R9", "remainder", remainder_o, '0);
    endtask

    task automatic test_unsigned();
        run_div("R1", 32'd7, 32'd2, 1'b0, 1'b0);
        run_div("R1", 32'd100, 32'd7, 1'b0, 1'b0);
        run_div("R1", 32'd3, 32'd10, 1'b0, 1'b0);
        run_div("R1", 32'd12345, 32'd12345, 1'b0, 1'b0);
        run_div("R1", 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0);
        run_div("R1", 32'hDEADBEEF, 32'h0000ABCD, 1'b0, 1'b0);
        run_div("R1", 32'hFFFFFFF9, 32'd2, 1'b0, 1'b0);
    endtask

    task automatic test_large_divisor();
        run_div("R7", 32'hFFFFFFFF, 32'h80000001, 1'b0, 1'b0);
        run_div("R7", 32'hF0000000, 32'hE0000000, 1'b0, 1'b0);
        run_div("R7", 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b0);
    endtask

    task automatic test_signed();
        run_div("R2", -32'sd7, 32'sd2, 1'b1, 1'b0);
        run_div("R2", 32'sd7, -32'sd2, 1'b1, 1'b0);
        run_div("R2", -32'sd7, -32'sd2, 1'b1, 1'b0);
        run_div("R2", 32'sd7, 32'sd2, 1'b1, 1'b0);
        run_div("R2", -32'sd1000003, 32'sd97, 1'b1, 1'b0);
    endtask

    task automatic test_min_over_neg1();
        run_div("R8", 32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0);
        check("R8", "explicit quotient", quotient_o, 32'h80000000);
        check("R8", "explicit remainder", remainder_o, 32'h0);
    endtask

    task automatic test_div_zero();
        run_div("R6", 32'h12345678, 32'h0, 1'b0, 1'b0);
        check("R6", "flag set", W'(div_zero_o), W'(1));
        run_div("R6", -32'sd9, 32'h0, 1'b1, 1'b0);
        run_div("R6", 32'd9, 32'd4, 1'b0, 1'b0);
        check("R6", "flag cleared", W'(div_zero_o), W'(0));
    endtask

    task automatic test_busy_ignore();
        run_div("R4", 32'd1000, 32'd33, 1'b0, 1'b1);
        run_div("R4", -32'sd77, 32'sd5, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_unsigned();
        test_large_divisor();
        test_signed();
        test_min_over_neg1();
        test_div_zero();
        test_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule